// File: doc/BRIEF.md
# SDRAM Controller Configuration Register Block

This block is the register file that software uses to set up a four-bank SDRAM controller. The register bus reaches it through two ports: a write to the index port selects one internal register, and a read or write on the data port then acts on that register. Held here are two bus error status words, an error address, the controller configuration word, a read-only status word, refresh, power-management, timing and ECC setup words, an ECC error status word and one configuration word per bank.

Beside the registers, the block decodes a physical address against the bank settings and reports whether an enabled bank claims it and which one. It also drives a level interrupt while any ECC error status bit is set. A small state machine tracks the controller enable (states CTL_OFF and CTL_ON, moved by the transitions T_ENABLE and T_DISABLE), and a second one tracks the interrupt (states IRQ_QUIET and IRQ_ACTIVE, moved by T_RAISE and T_DROP).

Top module: `sdram_cfg_regs`

## Requirements
- R1: A write with `port_sel`=0 stores the low 8 bits of `wr_data` as the register index; reading with `port_sel`=0 returns that index zero-extended; with `port_sel`=1 reads and writes act on the indexed register. Index map: 0x00 bus error status A, 0x08 bus error status B, 0x10 error address, 0x20 configuration, 0x24 status, 0x30 refresh, 0x34 power management, 0x40/0x44/0x48/0x4C bank 0..3, 0x80 timing, 0x94 ECC setup, 0x98 ECC error status.
- R2: After reset power management reads 0x07C00000, refresh 0x05F00000, timing 0x00854009, configuration 0x00800000, and every other register reads 0.
- R3: The two bus error status words set bits from `err0_set`/`err1_set` and clear every bit written as 1 (bits written as 0 stay); the status word ignores writes.
- R4: Stored values are masked: refresh keeps `wr_data & 0x3FF80000`, timing `& 0x018FC01F`, ECC setup `& 0x00F00000`, each bank `& 0xFFDEE001`; power management stores `(wr_data & 0xF8000000) | 0x07C00000`. Error address and configuration store the full word.
- R5: A configuration write that takes bit 31 from 0 to 1 enables the controller (T_ENABLE) and clears status bit 31; one that takes it from 1 to 0 disables it (T_DISABLE) and sets status bit 31.
- R6: Status bit 30 becomes 1 when a configuration write takes bit 30 from 0 to 1 and becomes 0 when one takes it from 1 to 0; status bits 29..0 read 0.
- R7: A bank spans base = word & 0xFF800000 up to but excluding base + (4 MiB << word[19:17]), computed without wrap past 2^32; `dec_hit` is 1 and `dec_bank` gives the bank number when `dec_addr` lies in an enabled bank.
- R8: A bank takes part in decoding only when its bit 0 is 1 and the controller is enabled; otherwise `dec_hit` is 0 for its range.
- R9: When several enabled banks claim the address, `dec_bank` reports the lowest-numbered one.
- R10: ECC error status sets bits from `ecc_err_set` and clears bits written as 1; a bit set and cleared in the same cycle ends up set.
- R11: `ecc_irq` is 1 exactly while the ECC error status is non-zero, changing on the same clock edge as the status.
- R12: Reading an index not in the map returns 0 and writing it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the selected port |
| port_sel | input | 1 | 0 = index port, 1 = data port |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the selected port (combinational) |
| err0_set | input | 32 | Bits to set in bus error status A |
| err1_set | input | 32 | Bits to set in bus error status B |
| ecc_err_set | input | 32 | Bits to set in ECC error status |
| dec_addr | input | 32 | Physical address to decode |
| dec_hit | output | 1 | An enabled bank claims `dec_addr` |
| dec_bank | output | 2 | Number of the claiming bank |
| ecc_irq | output | 1 | ECC error interrupt level |

## Verification
Every cycle the assertions hold the interrupt level equal to a non-zero ECC error status, keep the enable state machine in step with configuration bit 31, check the status bit on each enable edge, forbid a decode hit while disabled, and check the forced and masked bits of power management and the banks and the clearing effect of a write to a bus error status. Only the bench's scenarios can show the reset values, the exact arithmetic of bank ranges including the top of the address space, the lowest-bank priority on overlap, set-beats-clear on the ECC status and the silence of unmapped indices, because those need known stimulus and expected numbers.

// File: rtl/sdram_cfg_pkg.sv
package sdram_cfg_pkg;

    localparam int REG_W = 32;
    localparam int IDX_W = 8;

    // register index map
    localparam logic [IDX_W-1:0] IX_BERR_A  = 8'h00;
    localparam logic [IDX_W-1:0] IX_BERR_B  = 8'h08;
    localparam logic [IDX_W-1:0] IX_EADDR   = 8'h10;
    localparam logic [IDX_W-1:0] IX_CONF    = 8'h20;
    localparam logic [IDX_W-1:0] IX_STAT    = 8'h24;
    localparam logic [IDX_W-1:0] IX_REFR    = 8'h30;
    localparam logic [IDX_W-1:0] IX_PWR     = 8'h34;
    localparam logic [IDX_W-1:0] IX_BANK0   = 8'h40;
    localparam logic [IDX_W-1:0] IX_TIME    = 8'h80;
    localparam logic [IDX_W-1:0] IX_ECFG    = 8'h94;
    localparam logic [IDX_W-1:0] IX_ESTAT   = 8'h98;

    // store masks
    localparam logic [REG_W-1:0] MSK_REFR   = 32'h3FF8_0000;
    localparam logic [REG_W-1:0] MSK_TIME   = 32'h018F_C01F;
    localparam logic [REG_W-1:0] MSK_ECFG   = 32'h00F0_0000;
    localparam logic [REG_W-1:0] MSK_BANK   = 32'hFFDE_E001;
    localparam logic [REG_W-1:0] MSK_PWR    = 32'hF800_0000;
    localparam logic [REG_W-1:0] FRC_PWR    = 32'h07C0_0000;
    localparam logic [REG_W-1:0] MSK_BASE   = 32'hFF80_0000;

    // reset values
    localparam logic [REG_W-1:0] RST_PWR    = 32'h07C0_0000;
    localparam logic [REG_W-1:0] RST_REFR   = 32'h05F0_0000;
    localparam logic [REG_W-1:0] RST_TIME   = 32'h0085_4009;
    localparam logic [REG_W-1:0] RST_CONF   = 32'h0080_0000;

    // bank geometry
    localparam int BIT_EN      = 31;
    localparam int BIT_SR      = 30;
    localparam int SZ_LO       = 17;
    localparam int SZ_W        = 3;
    localparam int UNIT_SHIFT  = 22;   // 4 MiB

    typedef enum logic {
        CTL_OFF,
        CTL_ON
    } ctl_state_e;

    typedef enum logic {
        IRQ_QUIET,
        IRQ_ACTIVE
    } irq_state_e;

endpackage

// File: rtl/sdram_cfg_ctl_fsm.sv
module sdram_cfg_ctl_fsm
    import sdram_cfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic conf_wr,
    input  logic wbit_en,
    input  logic wbit_sr,
    input  logic conf_sr_q,
    output logic ctl_en,
    output logic stat_off,
    output logic stat_sr
);

    ctl_state_e state_q, state_d;
    logic t_enable, t_disable;

    assign t_enable  = conf_wr &&  wbit_en && (state_q == CTL_OFF);
    assign t_disable = conf_wr && !wbit_en && (state_q == CTL_ON);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CTL_OFF: if (t_enable)  state_d = CTL_ON;
            CTL_ON:  if (t_disable) state_d = CTL_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CTL_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_off <= 1'b0;
            stat_sr  <= 1'b0;
        end else begin
            if (t_enable)  stat_off <= 1'b0;
            if (t_disable) stat_off <= 1'b1;
            if (conf_wr && !conf_sr_q &&  wbit_sr) stat_sr <= 1'b1;
            if (conf_wr &&  conf_sr_q && !wbit_sr) stat_sr <= 1'b0;
        end
    end

    assign ctl_en = (state_q == CTL_ON);

endmodule

// File: rtl/sdram_cfg_irq_fsm.sv
module sdram_cfg_irq_fsm
    import sdram_cfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic esr_nz_next,
    output logic irq
);

    irq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (esr_nz_next)  state_d = IRQ_ACTIVE;   // T_RAISE
            IRQ_ACTIVE: if (!esr_nz_next) state_d = IRQ_QUIET;    // T_DROP
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        irq = (state_q == IRQ_ACTIVE);
    end

endmodule

// File: rtl/sdram_cfg_bank_dec.sv
module sdram_cfg_bank_dec
    import sdram_cfg_pkg::*;
#(
    parameter int NUM_BANKS  = 4,
    parameter int BANK_IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic [NUM_BANKS*REG_W-1:0] bank_words,
    input  logic                       ctl_en,
    input  logic [REG_W-1:0]           addr,
    output logic                       hit,
    output logic [BANK_IDX_W-1:0]      bank
);

    localparam int EXT_W = REG_W + 1;

    logic [NUM_BANKS-1:0] claim;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic [REG_W-1:0] word;
        logic [EXT_W-1:0] base_x, size_x, end_x, addr_x;
        logic [SZ_W-1:0]  szf;

        assign word   = bank_words[g*REG_W +: REG_W];
        assign szf    = word[SZ_LO +: SZ_W];
        assign base_x = {1'b0, word & MSK_BASE};
        assign size_x = EXT_W'(1) << (UNIT_SHIFT + int'(szf));
        assign end_x  = base_x + size_x;
        assign addr_x = {1'b0, addr};
        assign claim[g] = ctl_en && word[0] && (addr_x >= base_x) && (addr_x < end_x);
    end

    always_comb begin
        hit  = |claim;
        bank = '0;
        for (int i = NUM_BANKS - 1; i >= 0; i--) begin
            if (claim[i]) bank = BANK_IDX_W'(i);
        end
    end

endmodule

// File: rtl/sdram_cfg_regs.sv
module sdram_cfg_regs
    import sdram_cfg_pkg::*;
#(
    parameter int NUM_BANKS  = 4,
    parameter int BANK_IDX_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  port_sel,
    input  logic [REG_W-1:0]      wr_data,
    output logic [REG_W-1:0]      rd_data,
    input  logic [REG_W-1:0]      err0_set,
    input  logic [REG_W-1:0]      err1_set,
    input  logic [REG_W-1:0]      ecc_err_set,
    input  logic [REG_W-1:0]      dec_addr,
    output logic                  dec_hit,
    output logic [BANK_IDX_W-1:0] dec_bank,
    output logic                  ecc_irq
);

    localparam int BANK_STRIDE = 4;

    logic [IDX_W-1:0] idx_q;
    logic [REG_W-1:0] berr_a_q, berr_b_q, eaddr_q, conf_q;
    logic [REG_W-1:0] refr_q, pwr_q, time_q, ecfg_q, estat_q;
    logic [REG_W-1:0] estat_d;
    logic [NUM_BANKS*REG_W-1:0] bank_q;
    logic             data_wr;
    logic             ctl_en, stat_off, stat_sr;
    logic [REG_W-1:0] stat_word;

    assign data_wr   = wr_en && port_sel;
    assign stat_word = {stat_off, stat_sr, {(REG_W-2){1'b0}}};

    function automatic logic hit_ix(input logic [IDX_W-1:0] cur,
                                    input logic [IDX_W-1:0] ix);
        return cur == ix;
    endfunction

    // index port
    always_ff @(posedge clk) begin
        if (!rst_n)                  idx_q <= '0;
        else if (wr_en && !port_sel) idx_q <= wr_data[IDX_W-1:0];
    end

    // clear-on-one words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            berr_a_q <= '0;
            berr_b_q <= '0;
        end else begin
            berr_a_q <= (berr_a_q & ~((data_wr && hit_ix(idx_q, IX_BERR_A)) ? wr_data : '0)) | err0_set;
            berr_b_q <= (berr_b_q & ~((data_wr && hit_ix(idx_q, IX_BERR_B)) ? wr_data : '0)) | err1_set;
        end
    end

    assign estat_d = (estat_q & ~((data_wr && hit_ix(idx_q, IX_ESTAT)) ? wr_data : '0)) | ecc_err_set;

    always_ff @(posedge clk) begin
        if (!rst_n) estat_q <= '0;
        else        estat_q <= estat_d;
    end

    // plain and masked words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eaddr_q <= '0;
            conf_q  <= RST_CONF;
            refr_q  <= RST_REFR;
            pwr_q   <= RST_PWR;
            time_q  <= RST_TIME;
            ecfg_q  <= '0;
        end else if (data_wr) begin
            if (hit_ix(idx_q, IX_EADDR)) eaddr_q <= wr_data;
            if (hit_ix(idx_q, IX_CONF))  conf_q  <= wr_data;
            if (hit_ix(idx_q, IX_REFR))  refr_q  <= wr_data & MSK_REFR;
            if (hit_ix(idx_q, IX_PWR))   pwr_q   <= (wr_data & MSK_PWR) | FRC_PWR;
            if (hit_ix(idx_q, IX_TIME))  time_q  <= wr_data & MSK_TIME;
            if (hit_ix(idx_q, IX_ECFG))  ecfg_q  <= wr_data & MSK_ECFG;
        end
    end

    // bank words
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        localparam logic [IDX_W-1:0] IX_THIS = IX_BANK0 + IDX_W'(g * BANK_STRIDE);
        always_ff @(posedge clk) begin
            if (!rst_n)
                bank_q[g*REG_W +: REG_W] <= '0;
            else if (data_wr && hit_ix(idx_q, IX_THIS))
                bank_q[g*REG_W +: REG_W] <= wr_data & MSK_BANK;
        end
    end

    // read mux
    always_comb begin
        rd_data = '0;
        if (!port_sel) begin
            rd_data = REG_W'(idx_q);
        end else begin
            case (idx_q)
                IX_BERR_A: rd_data = berr_a_q;
                IX_BERR_B: rd_data = berr_b_q;
                IX_EADDR:  rd_data = eaddr_q;
                IX_CONF:   rd_data = conf_q;
                IX_STAT:   rd_data = stat_word;
                IX_REFR:   rd_data = refr_q;
                IX_PWR:    rd_data = pwr_q;
                IX_TIME:   rd_data = time_q;
                IX_ECFG:   rd_data = ecfg_q;
                IX_ESTAT:  rd_data = estat_q;
                default:   rd_data = '0;
            endcase
            for (int i = 0; i < NUM_BANKS; i++) begin
                if (idx_q == IX_BANK0 + IDX_W'(i * BANK_STRIDE))
                    rd_data = bank_q[i*REG_W +: REG_W];
            end
        end
    end

    sdram_cfg_ctl_fsm i_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .conf_wr   (data_wr && hit_ix(idx_q, IX_CONF)),
        .wbit_en   (wr_data[BIT_EN]),
        .wbit_sr   (wr_data[BIT_SR]),
        .conf_sr_q (conf_q[BIT_SR]),
        .ctl_en    (ctl_en),
        .stat_off  (stat_off),
        .stat_sr   (stat_sr)
    );

    sdram_cfg_irq_fsm i_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .esr_nz_next (|estat_d),
        .irq         (ecc_irq)
    );

    sdram_cfg_bank_dec #(
        .NUM_BANKS  (NUM_BANKS),
        .BANK_IDX_W (BANK_IDX_W)
    ) i_dec (
        .bank_words (bank_q),
        .ctl_en     (ctl_en),
        .addr       (dec_addr),
        .hit        (dec_hit),
        .bank       (dec_bank)
    );

endmodule

// File: rtl/sdram_cfg_regs_chk.sv
module sdram_cfg_regs_chk
    import sdram_cfg_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic                       port_sel,
    input logic [REG_W-1:0]           wr_data,
    input logic [IDX_W-1:0]           idx_q,
    input logic [REG_W-1:0]           berr_a_q,
    input logic [REG_W-1:0]           err0_set,
    input logic [REG_W-1:0]           conf_q,
    input logic                       ctl_en,
    input logic                       stat_off,
    input logic [REG_W-1:0]           pwr_q,
    input logic [NUM_BANKS*REG_W-1:0] bank_q,
    input logic [REG_W-1:0]           estat_q,
    input logic                       ecc_irq,
    input logic                       dec_hit
);

    logic bank_bad;
    always_comb begin
        bank_bad = 1'b0;
        for (int i = 0; i < NUM_BANKS; i++)
            if ((bank_q[i*REG_W +: REG_W] & ~MSK_BANK) != '0) bank_bad = 1'b1;
    end

    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_irq == (estat_q != '0)); // R11

    AST_EN_FOLLOWS_CONF: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_en == conf_q[BIT_EN]); // R5

    AST_EN_RISE_STAT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_en) |-> !stat_off); // R5

    AST_EN_FALL_STAT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_en) |-> stat_off); // R5

    AST_NO_HIT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        dec_hit |-> ctl_en); // R8

    AST_PWR_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_q & ~MSK_PWR) == FRC_PWR); // R4

    AST_BANK_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_bad); // R4

    AST_BERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && port_sel && idx_q == IX_BERR_A && err0_set == '0)
        |=> ((berr_a_q & $past(wr_data)) == '0)); // R3

endmodule

bind sdram_cfg_regs sdram_cfg_regs_chk #(.NUM_BANKS(NUM_BANKS)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .port_sel (port_sel),
    .wr_data  (wr_data),
    .idx_q    (idx_q),
    .berr_a_q (berr_a_q),
    .err0_set (err0_set),
    .conf_q   (conf_q),
    .ctl_en   (ctl_en),
    .stat_off (stat_off),
    .pwr_q    (pwr_q),
    .bank_q   (bank_q),
    .estat_q  (estat_q),
    .ecc_irq  (ecc_irq),
    .dec_hit  (dec_hit)
);

// File: tb/test_sdram_cfg_regs.sv
module test_sdram_cfg_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        port_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [31:0] err0_set = '0;
    logic [31:0] err1_set = '0;
    logic [31:0] ecc_err_set = '0;
    logic [31:0] dec_addr = '0;
    logic        dec_hit;
    logic [1:0]  dec_bank;
    logic        ecc_irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sdram_cfg_regs i_sdram_cfg_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .port_sel(port_sel),
        .wr_data(wr_data), .rd_data(rd_data), .err0_set(err0_set),
        .err1_set(err1_set), .ecc_err_set(ecc_err_set), .dec_addr(dec_addr),
        .dec_hit(dec_hit), .dec_bank(dec_bank), .ecc_irq(ecc_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic put(input logic ps, input logic [31:0] d);
        @(negedge clk);
        port_sel = ps; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic wreg(input logic [7:0] ix, input logic [31:0] d);
        put(1'b0, {24'h0, ix});
        put(1'b1, d);
    endtask

    task automatic rreg(input logic [7:0] ix, output logic [31:0] v);
        put(1'b0, {24'h0, ix});
        port_sel = 1'b1;
        #1 v = rd_data;
    endtask

    task automatic dec(input logic [31:0] a, input logic eh, input logic [1:0] eb, input string tag);
        @(negedge clk);
        dec_addr = a;
        #1;
        check({tag, " hit"}, {31'h0, dec_hit}, {31'h0, eh});
        if (eh) check({tag, " bank"}, {30'h0, dec_bank}, {30'h0, eb});
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rreg(8'h34, v); check("R2 pwr", v, 32'h07C00000);
        rreg(8'h30, v); check("R2 refr", v, 32'h05F00000);
        rreg(8'h80, v); check("R2 time", v, 32'h00854009);
        rreg(8'h20, v); check("R2 conf", v, 32'h00800000);
        rreg(8'h24, v); check("R2 stat", v, 32'h0);
        rreg(8'h4C, v); check("R2 bank3", v, 32'h0);
        rreg(8'h98, v); check("R2 estat", v, 32'h0);
        check("R2 irq", {31'h0, ecc_irq}, 32'h0);
    endtask

    task automatic t_indirect();
        logic [31:0] v;
        put(1'b0, 32'h0000_1234);
        port_sel = 1'b0; #1;
        check("R1 index readback", rd_data, 32'h34);
        wreg(8'h10, 32'hDEAD_BEEF);
        rreg(8'h10, v); check("R1 data port", v, 32'hDEADBEEF);
    endtask

    task automatic t_masks();
        logic [31:0] v;
        wreg(8'h30, 32'hFFFF_FFFF); rreg(8'h30, v); check("R4 refr", v, 32'h3FF80000);
        wreg(8'h80, 32'hFFFF_FFFF); rreg(8'h80, v); check("R4 time", v, 32'h018FC01F);
        wreg(8'h94, 32'hFFFF_FFFF); rreg(8'h94, v); check("R4 ecfg", v, 32'h00F00000);
        wreg(8'h34, 32'hFFFF_FFFF); rreg(8'h34, v); check("R4 pwr ones", v, 32'hFFC00000);
        wreg(8'h34, 32'h0);         rreg(8'h34, v); check("R4 pwr zero", v, 32'h07C00000);
        wreg(8'h48, 32'hFFFF_FFFF); rreg(8'h48, v); check("R4 bank2", v, 32'hFFDEE001);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        @(negedge clk); err0_set = 32'h0000_00F0; err1_set = 32'h0F00_0000;
        @(negedge clk); err0_set = '0; err1_set = '0;
        wreg(8'h00, 32'h0000_0030); rreg(8'h00, v); check("R3 berrA clear", v, 32'h000000C0);
        wreg(8'h08, 32'h0100_0000); rreg(8'h08, v); check("R3 berrB clear", v, 32'h0E000000);
        rreg(8'h24, v);
        wreg(8'h24, 32'hFFFF_FFFF);
        begin
            logic [31:0] w;
            rreg(8'h24, w); check("R3 status ignores write", w, v);
        end
    endtask

    task automatic t_enable();
        logic [31:0] v;
        wreg(8'h20, 32'hC000_0000);
        rreg(8'h24, v); check("R5 R6 enable", v, 32'h40000000);
        wreg(8'h20, 32'h0000_0000);
        rreg(8'h24, v); check("R5 R6 disable", v, 32'h80000000);
        wreg(8'h20, 32'h8000_0000);
        rreg(8'h24, v); check("R5 re-enable", v, 32'h00000000);
    endtask

    task automatic t_decode();
        wreg(8'h20, 32'h0000_0000);
        wreg(8'h40, 32'h0082_0001);   // base 8 MiB, 8 MiB
        wreg(8'h44, 32'h0004_0001);   // base 0, 16 MiB
        wreg(8'h48, 32'hFF8E_0000);   // not valid yet
        wreg(8'h4C, 32'hF00E_0001);   // base 0xF0000000, 512 MiB
        dec(32'h0090_0000, 1'b0, 2'd0, "R8 disabled");
        wreg(8'h20, 32'h8000_0000);
        dec(32'h0090_0000, 1'b1, 2'd0, "R9 overlap low wins");
        dec(32'h0010_0000, 1'b1, 2'd1, "R7 bank1");
        dec(32'h0100_0000, 1'b0, 2'd0, "R7 past end");
        dec(32'hFFFF_FFFF, 1'b1, 2'd3, "R7 top of space");
        dec(32'hEFFF_FFFF, 1'b0, 2'd0, "R7 below base");
        dec(32'hFF90_0000, 1'b1, 2'd3, "R8 invalid bank skipped");
        wreg(8'h48, 32'hFF8E_0001);
        dec(32'hFF90_0000, 1'b1, 2'd2, "R9 bank2 over bank3");
        wreg(8'h20, 32'h0000_0000);
        dec(32'hFF90_0000, 1'b0, 2'd0, "R8 disabled again");
    endtask

    task automatic t_ecc();
        logic [31:0] v;
        @(negedge clk); ecc_err_set = 32'h5;
        @(negedge clk); ecc_err_set = '0;
        check("R11 irq raised", {31'h0, ecc_irq}, 32'h1);
        wreg(8'h98, 32'h1); rreg(8'h98, v); check("R10 clear one", v, 32'h4);
        @(negedge clk); port_sel = 1'b1; wr_data = 32'h4; wr_en = 1'b1; ecc_err_set = 32'h4;
        @(negedge clk); wr_en = 1'b0; wr_data = '0; ecc_err_set = '0;
        rreg(8'h98, v); check("R10 set beats clear", v, 32'h4);
        check("R11 irq held", {31'h0, ecc_irq}, 32'h1);
        wreg(8'h98, 32'hFFFF_FFFF); rreg(8'h98, v); check("R10 cleared", v, 32'h0);
        check("R11 irq dropped", {31'h0, ecc_irq}, 32'h0);
    endtask

    task automatic t_unimpl();
        logic [31:0] v;
        wreg(8'h10, 32'h1111_2222);
        wreg(8'h50, 32'hFFFF_FFFF);
        rreg(8'h50, v); check("R12 unmapped reads zero", v, 32'h0);
        rreg(8'h10, v); check("R12 neighbour kept", v, 32'h11112222);
        rreg(8'h4C, v); check("R12 bank3 kept", v, 32'hF00E0001);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_indirect();
        t_masks();
        t_w1c();
        t_enable();
        t_decode();
        t_ecc();
        t_unimpl();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule